// File: doc/BRIEF.md
# Fast-Page DRAM Controller

This block sits between a simple word-request port and one multiplexed-address x4 DRAM device. Each host request carries a 20-bit word address, a write flag and 4 bits of write data. The controller turns it into row-strobe and column-strobe sequences. The upper half of the address goes to the shared address pins when the row strobe falls. The lower half goes to the same pins when the column strobe falls. Read data comes back as a one-cycle valid pulse.

The controller keeps a row open only while requests keep arriving back to back. When the next request hits the same row, it issues column-only cycles with the row strobe held low. On a row miss, or when no request is waiting, it raises the row strobe and waits a programmable precharge time before opening another row. All strobe widths are counted in clocks and set by parameters. Writes lower the write-enable line before the column strobe falls, so the device never drives the shared data bus while the controller does. A refresh agent can ask for the device through a request/grant pair. The controller then stops taking host requests, closes any open row and grants.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: At each falling edge of `ras_n`, `mem_addr` carries request address bits [19:10]. At each falling edge of `cas_n`, `mem_addr` carries request address bits [9:0]. Requests are served in the order they were accepted.
- R2: For a write, `we_n` is low in the cycle before `cas_n` falls and stays low while `cas_n` is low. In that window `dq_oe` is 1 and `dq_out` equals the request's write data. `dq_oe` is never 1 while `we_n` is high.
- R3: For a read, `we_n` stays high and `dq_oe` stays 0 while `cas_n` is low. `dq_in` is captured on the T_RD-th rising clock edge after `cas_n` falls. It is returned on `rd_data` with `rd_valid` high for exactly one cycle and equals the last data written to that address, or 0 if the address was never written.
- R4: A request accepted while a row is open whose row matches that row is served with a column strobe only, without a new `ras_n` falling edge.
- R5: `ras_n` stays high for at least T_RP cycles before each falling edge (precharge), including when a row is closed because of a row miss.
- R6: When no request is waiting after an access completes, the row is closed: `ras_n` and `cas_n` both return high and stay high while idle.
- R7: `ras_n` stays low for at least T_RAS cycles each time it falls.
- R8: `cas_n` stays low for at least T_CAS cycles. Between two column strobes it stays high for at least T_CP cycles.
- R9: While `ref_req` is 1, `req_ready` is 0. `ref_gnt` is 1 only while `ras_n` and `cas_n` are both high, and no column strobe is issued while it is 1.
- R10: `cas_n` is low only while `ras_n` is low.
- R11: After reset, `ras_n`, `cas_n` and `we_n` are 1, and `dq_oe`, `rd_valid` and `ref_gnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request on this cycle's rising edge |
| req_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read data |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh agent asks for the device |
| ref_gnt | output | 1 | Device handed to the refresh agent |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | 10 | Multiplexed row/column address pins |
| dq_out | output | 4 | Data driven toward the device |
| dq_oe | output | 1 | Output enable for `dq_out` on the shared bus |
| dq_in | input | 4 | Data returned by the device |

## Verification
The bench builds the controller with T_RP=2, T_RCD=2, T_RAS=9, T_CAS=3, T_CP=2 and T_RD=2. With T_RAS longer than one row-open, column-strobe and column-recovery sequence, the idle-close and row-miss paths must wait on the row-width counter rather than on the phase counter. With T_RD smaller than T_CAS, the read capture point lies inside the column pulse and not at its end. The random traffic is limited to four rows and eight columns, so page hits, row misses, overwrites and refresh preemption of an open row all occur often.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int DQ_W   = 4;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [3:0] {
        ST_IDLE,   // row closed, precharged
        ST_ACT,    // row strobe low, waiting row-to-column delay
        ST_CAS,    // column strobe low
        ST_CP,     // column strobe high recovery
        ST_OPEN,   // row open, column strobe high, deciding
        ST_COL,    // column address set up for a page hit
        ST_CLOSE,  // waiting minimum row-low width before closing
        ST_PRE,    // row strobe high, precharge count
        ST_REF     // device granted to refresh agent
    } st_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic [DQ_W-1:0]  wd;
    } acc_t;

    function automatic acc_t split_req(input logic [ADDR_W-1:0] addr,
                                       input logic wr,
                                       input logic [DQ_W-1:0] wd);
        acc_t a;
        a.row = addr[ADDR_W-1:COL_W];
        a.col = addr[COL_W-1:0];
        a.wr  = wr;
        a.wd  = wd;
        return a;
    endfunction

    function automatic logic [PIN_W-1:0] row_pins(input logic [ROW_W-1:0] r);
        return PIN_W'(r);
    endfunction

    function automatic logic [PIN_W-1:0] col_pins(input logic [COL_W-1:0] c);
        return PIN_W'(c);
    endfunction

endpackage

// File: rtl/fpm_tmr.sv
// Loadable down-counter: after load with len, done rises len cycles later.
module fpm_tmr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done,
    output logic [W-1:0] rem
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign done = (cnt == '0);
    assign rem  = cnt;
endmodule

// File: rtl/fpm_row_reg.sv
// Holds the currently open row and reports whether a request hits it.
module fpm_row_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] set_row,
    input  logic [W-1:0] cmp_row,
    output logic         hit
);
    logic [W-1:0] open_row;
    logic         open_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_row <= '0;
            open_vld <= 1'b0;
        end else if (set) begin
            open_row <= set_row;
            open_vld <= 1'b1;
        end else if (clr) begin
            open_vld <= 1'b0;
        end
    end

    assign hit = open_vld && (open_row == cmp_row);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int TMR_W = 4,
    parameter int T_RP  = 2,   // precharge (row strobe high) cycles
    parameter int T_RCD = 2,   // row strobe fall to column strobe fall
    parameter int T_RAS = 7,   // minimum row strobe low cycles
    parameter int T_CAS = 2,   // column strobe low cycles
    parameter int T_CP  = 1,   // minimum column strobe high cycles
    parameter int T_RD  = 2    // capture edge after column strobe fall, <= T_CAS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [PIN_W-1:0]  mem_addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in
);
    localparam logic [TMR_W-1:0] RD_REM = TMR_W'(T_CAS - T_RD);

    st_e  state, nxt;
    acc_t in_acc, pend, act_acc;
    logic have_pend;
    logic accept, row_hit;
    logic ph_load, ph_done, ras_load, ras_done;
    logic [TMR_W-1:0] ph_len, ph_rem, ras_rem;
    logic row_clr;

    assign in_acc    = split_req(req_addr, req_we, req_wdata);
    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_req;
    assign accept    = req_valid && req_ready;
    assign act_acc   = (state == ST_PRE) ? pend : in_acc;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (ref_req) nxt = ST_REF;
                      else if (req_valid) nxt = ST_ACT;
            ST_ACT:   if (ph_done) nxt = ST_CAS;
            ST_CAS:   if (ph_done) nxt = ST_CP;
            ST_CP:    if (ph_done) nxt = ST_OPEN;
            ST_OPEN:  if (req_valid && !ref_req && row_hit) nxt = ST_COL;
                      else nxt = ST_CLOSE;
            ST_COL:   nxt = ST_CAS;
            ST_CLOSE: if (ras_done) nxt = ST_PRE;
            ST_PRE:   if (ph_done) begin
                          if (ref_req) nxt = ST_REF;
                          else if (have_pend) nxt = ST_ACT;
                          else nxt = ST_IDLE;
                      end
            ST_REF:   if (!ref_req) nxt = ST_PRE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ph_load = (nxt != state) &&
                  ((nxt == ST_ACT) || (nxt == ST_CAS) || (nxt == ST_CP) || (nxt == ST_PRE));
        case (nxt)
            ST_ACT:  ph_len = TMR_W'(T_RCD);
            ST_CAS:  ph_len = TMR_W'(T_CAS);
            ST_CP:   ph_len = TMR_W'(T_CP);
            default: ph_len = TMR_W'(T_RP);
        endcase
    end

    assign ras_load = (nxt == ST_ACT) && (state != ST_ACT);
    assign row_clr  = (nxt == ST_PRE) && (state == ST_CLOSE);

    fpm_tmr #(.W(TMR_W)) u_ph_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .len(ph_len),
        .done(ph_done), .rem(ph_rem)
    );

    fpm_tmr #(.W(TMR_W)) u_ras_tmr (
        .clk(clk), .rst(rst), .load(ras_load), .len(TMR_W'(T_RAS)),
        .done(ras_done), .rem(ras_rem)
    );

    fpm_row_reg #(.W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .set(ras_load), .clr(row_clr),
        .set_row(act_acc.row), .cmp_row(in_acc.row), .hit(row_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            dq_out    <= '0;
            mem_addr  <= '0;
            pend      <= '0;
            have_pend <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            ref_gnt   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if ((state == ST_CAS) && !pend.wr && (ph_rem == RD_REM)) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
            end
            if (accept) begin
                pend <= in_acc;
            end
            if ((state == ST_OPEN) && accept && !row_hit) begin
                have_pend <= 1'b1;
            end
            if (ras_load) begin
                ras_n     <= 1'b0;
                mem_addr  <= row_pins(act_acc.row);
                we_n      <= !act_acc.wr;
                dq_oe     <= act_acc.wr;
                dq_out    <= act_acc.wd;
                have_pend <= 1'b0;
            end
            if ((state == ST_OPEN) && (nxt == ST_COL)) begin
                mem_addr <= col_pins(in_acc.col);
                we_n     <= !in_acc.wr;
                dq_oe    <= in_acc.wr;
                dq_out   <= in_acc.wd;
            end
            if ((state == ST_ACT) && (nxt == ST_CAS)) begin
                cas_n    <= 1'b0;
                mem_addr <= col_pins(pend.col);
            end
            if (state == ST_COL) begin
                cas_n <= 1'b0;
            end
            if ((state == ST_CAS) && (nxt == ST_CP)) begin
                cas_n <= 1'b1;
                we_n  <= 1'b1;
                dq_oe <= 1'b0;
            end
            if (row_clr) begin
                ras_n <= 1'b1;
            end
            ref_gnt <= (nxt == ST_REF);
            state   <= nxt;
        end
    end
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter int T_RP  = 2,
    parameter int T_RAS = 7,
    parameter int T_CAS = 2,
    parameter int T_CP  = 1
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic rd_valid,
    input logic ref_gnt
);
    logic [7:0] ras_lo, ras_hi, cas_lo, cas_hi;

    function automatic logic [7:0] sat_inc(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo <= '0;
            cas_lo <= '0;
            ras_hi <= 8'hFF;
            cas_hi <= 8'hFF;
        end else begin
            ras_lo <= ras_n ? 8'd0 : sat_inc(ras_lo);
            ras_hi <= ras_n ? sat_inc(ras_hi) : 8'd0;
            cas_lo <= cas_n ? 8'd0 : sat_inc(cas_lo);
            cas_hi <= cas_n ? sat_inc(cas_hi) : 8'd0;
        end
    end

    assert_ras_low_min_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_lo >= 8'(T_RAS)));

    assert_precharge_min_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_hi >= 8'(T_RP)));

    assert_cas_low_min_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> (cas_lo >= 8'(T_CAS)));

    assert_cas_high_min_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (cas_hi >= 8'(T_CP)));

    assert_cas_inside_row_R10: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    assert_early_write_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));

    assert_bus_direction_R2: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !we_n);

    assert_grant_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (ras_n && cas_n));

    assert_read_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
    .T_RP(T_RP), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_CP(T_CP)
) u_fpm_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_oe(dq_oe), .rd_valid(rd_valid), .ref_gnt(ref_gnt)
);

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
    localparam int P_RP = 2, P_RCD = 2, P_RAS = 9, P_CAS = 3, P_CP = 2, P_RD = 2;

    typedef struct {
        logic [19:0] addr;
        logic        wr;
        logic [3:0]  wd;
    } xact_t;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0, dq_in = '0;
    logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, dq_oe;
    logic [3:0] rd_data, dq_out;
    logic [9:0] mem_addr;

    int n_chk = 0, n_fail = 0, n_ras_fall = 0;
    bit ref_on = 1'b0;
    xact_t exp_q[$];
    logic [3:0] rd_exp[$];
    logic [3:0] dmem[int];
    logic [3:0] refm[int];

    always #4 clk = ~clk;

    fpm_dram_ctrl #(.TMR_W(4), .T_RP(P_RP), .T_RCD(P_RCD), .T_RAS(P_RAS),
                    .T_CAS(P_CAS), .T_CP(P_CP), .T_RD(P_RD)) i_fpm_dram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_rd(input logic [19:0] a);
        return refm.exists(int'(a)) ? refm[int'(a)] : 4'h0;
    endfunction

    function automatic logic [3:0] dev_rd(input logic [19:0] a);
        return dmem.exists(int'(a)) ? dmem[int'(a)] : 4'h0;
    endfunction

    // DRAM model and protocol monitor, sampled at the falling clock edge
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    int ras_run = 100, cas_run = 100;
    logic [9:0] cur_row = '0, cur_col = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (ras_n != p_ras) begin
                    if (!ras_n) begin
                        chk(ras_run >= P_RP, "R5", "precharge cycles", ras_run, P_RP);
                        cur_row = mem_addr;
                        n_ras_fall++;
                    end else begin
                        chk(ras_run >= P_RAS, "R7", "row low cycles", ras_run, P_RAS);
                    end
                    ras_run = 1;
                end else ras_run++;
                if (cas_n != p_cas) begin
                    if (!cas_n) begin
                        xact_t e;
                        chk(!ras_n, "R10", "column strobe with row closed", ras_n, 0);
                        chk(cas_run >= P_CP, "R8", "column high cycles", cas_run, P_CP);
                        chk(!ref_gnt, "R9", "column strobe during grant", ref_gnt, 0);
                        cur_col = mem_addr;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R1", "column strobe with no request", 1, 0);
                        end else begin
                            e = exp_q.pop_front();
                            chk({cur_row, cur_col} == e.addr, "R1", "row/column address",
                                {cur_row, cur_col}, e.addr);
                            if (e.wr) begin
                                chk(!we_n && !p_we && dq_oe && (dq_out == e.wd), "R2",
                                    "early write data/enable", {p_we, we_n, dq_oe, dq_out},
                                    {3'b001, e.wd});
                                dmem[int'({cur_row, cur_col})] = dq_out;
                            end else begin
                                chk(we_n && !dq_oe, "R3", "read keeps WE high, bus off",
                                    {we_n, dq_oe}, 2'b10);
                            end
                        end
                    end else begin
                        chk(cas_run >= P_CAS, "R8", "column low cycles", cas_run, P_CAS);
                    end
                    cas_run = 1;
                end else cas_run++;
                if (dq_oe) chk(!we_n, "R2", "bus driven with WE high", we_n, 0);
                if (ref_gnt) chk(ras_n && cas_n && !req_ready, "R9", "grant state",
                                 {ras_n, cas_n, req_ready}, 3'b110);
                if (ref_req) chk(!req_ready, "R9", "ready during refresh request", req_ready, 0);
                if (rd_valid) begin
                    if (rd_exp.size() == 0) chk(1'b0, "R3", "unexpected read valid", 1, 0);
                    else begin
                        logic [3:0] x;
                        x = rd_exp.pop_front();
                        chk(rd_data == x, "R3", "read data", rd_data, x);
                    end
                end
                dq_in = (!cas_n && we_n) ? dev_rd({cur_row, cur_col}) : 4'h0;
                p_ras = ras_n; p_cas = cas_n; p_we = we_n;
            end
        end
    end

    // Refresh agent
    initial begin
        forever begin
            @(negedge clk); #1;
            if (ref_on && ($urandom % 70 == 0)) begin
                ref_req = 1'b1;
                do begin @(negedge clk); #1; end while (!ref_gnt);
                repeat (3) begin @(negedge clk); #1; end
                ref_req = 1'b0;
            end
        end
    end

    // Caller is at negedge+2; returns at negedge+2 after acceptance edge.
    task automatic do_req(input logic [19:0] a, input logic w, input logic [3:0] d);
        xact_t e;
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        while (!req_ready) begin @(negedge clk); #2; end
        e.addr = a; e.wr = w; e.wd = d;
        exp_q.push_back(e);
        if (w) refm[int'(a)] = d;
        else rd_exp.push_back(ref_rd(a));
        @(negedge clk); #2;
    endtask

    task automatic go_idle(input int n);
        req_valid = 1'b0;
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic drain();
        int k = 0;
        req_valid = 1'b0;
        while ((exp_q.size() != 0 || rd_exp.size() != 0) && k < 2000) begin
            @(negedge clk); #2; k++;
        end
        go_idle(30);
    endtask

    initial begin
        int n0, s;
        s = $urandom(32'h1F2E3D);
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n && !dq_oe && !rd_valid && !ref_gnt, "R11",
            "reset outputs", {ras_n, cas_n, we_n, dq_oe, rd_valid, ref_gnt}, 6'b111000);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;

        // R4: same-row requests back to back share one row opening
        n0 = n_ras_fall;
        do_req({10'h155, 10'h001}, 1'b1, 4'hA);
        do_req({10'h155, 10'h002}, 1'b1, 4'h5);
        do_req({10'h155, 10'h001}, 1'b0, 4'h0);
        do_req({10'h155, 10'h002}, 1'b0, 4'h0);
        drain();
        chk(n_ras_fall - n0 == 1, "R4", "row openings for page hits", n_ras_fall - n0, 1);
        chk(ras_n && cas_n, "R6", "row closed when idle", {ras_n, cas_n}, 2'b11);

        // R5: row miss closes and reopens; unwritten address reads 0 (R3)
        n0 = n_ras_fall;
        do_req({10'h3FF, 10'h3FF}, 1'b1, 4'hF);
        do_req({10'h000, 10'h000}, 1'b0, 4'h0);
        do_req({10'h3FF, 10'h3FF}, 1'b0, 4'h0);
        drain();
        chk(n_ras_fall - n0 == 3, "R5", "row openings for misses", n_ras_fall - n0, 3);
        chk(ras_n && cas_n, "R6", "row closed after misses", {ras_n, cas_n}, 2'b11);

        // Random traffic with refresh preemption
        ref_on = 1'b1;
        for (int i = 0; i < 500; i++) begin
            logic [19:0] a;
            a = {8'h0, 2'($urandom % 4), 7'h0, 3'($urandom % 8)};
            do_req(a, 1'($urandom % 2), 4'($urandom));
            if ($urandom % 6 == 0) go_idle(1 + $urandom % 12);
        end
        ref_on = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R1", "all requests served", exp_q.size(), 0);
        chk(ras_n && cas_n, "R6", "row closed at end", {ras_n, cas_n}, 2'b11);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule